// File: doc/BRIEF.md
# Windowed Watchdog Timer with Register Locks

This block is a watchdog for a system running from a 16 MHz reference. It starts counting as soon as reset is released. Software must keep reloading it with a two-word key written to a service register. If the count runs out, the block responds in one of three programmed ways: a reset request, an interrupt, or an interrupt on the first expiry and a reset request on the next one. An optional window mode also treats servicing that comes too early as a fault.

The configuration registers can be frozen in two ways. A soft freeze is lifted by a separate two-word unlock key. A hard freeze holds until the next reset. When enabled, a low-power input pauses the count. All access goes through a simple single-cycle register port with a combinational read path. Writes take effect at the clock edge that captures them.

Register map (3-bit word address): 0 control, 1 timeout, 2 window, 3 service key, 4 status, 5 unlock key, 6 live count (read only).

Control bits:
- bit 0: run enable
- bit 1: window mode
- bits 3:2: response (0 reset, 1 interrupt, 2 interrupt then reset, 3 reset)
- bit 4: pause in low power
- bit 5: soft freeze
- bit 6: hard freeze

Top module: `wdt_window`

## Requirements
- R1: After reset, control reads 1 (counting enabled, reset response, no freeze), timeout reads 160000, window reads 0, both outputs are low, and the live count falls by one each cycle.
- R2: Writing 16'hA602 and then 16'hB480 to the service register in consecutive service writes loads the live count with the timeout value. Any other value between them, the reverse order, or an unknown value cancels the sequence, and the count is left untouched.
- R3: In reset response, after a reload to T, the reset request rises at the clock edge T+1 counting cycles later. It then stays high until reset.
- R4: In interrupt response, each expiry sets a sticky interrupt flag (status bit 0, driven on the interrupt pin) and reloads the count, and no reset request is ever made. Writing status with bit 0 set clears the flag. Writing bit 0 as zero leaves it set.
- R5: In interrupt-then-reset response, the first expiry raises the interrupt and reloads. An expiry with no valid service since the previous one raises the reset request. A valid service cancels that pending stage, but it does not clear the interrupt flag.
- R6: In window mode, a valid service while the count is above the window value counts as an expiry: the programmed response happens at that edge and the count reloads. A service at or below the window value is a normal reload.
- R7: While the soft freeze is set, writes to control, timeout and window are dropped. Writing 16'hC520 and then 16'hD928 to the unlock register clears the soft freeze. Any other sequence leaves it set.
- R8: Once the hard freeze is set, control, timeout and window cannot change, and the unlock key has no effect, until reset.
- R9: With the low-power pause bit set, the count holds while the low-power input is high. With that bit clear, the input has no effect.
- R10: With the run-enable bit clear, the count holds and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| lp_halt | input | 1 | Low-power mode indication |
| wdt_irq | output | 1 | Timeout interrupt, level, sticky flag |
| wdt_reset_req | output | 1 | Reset request, held until reset |

## Verification
Every register write, key hit and freeze change takes effect at the edge that captures the write. The bench therefore reads back at the following falling edge. After a reload to T, an expiry shows at the outputs on the edge T+1 cycles later. The bench checks both outputs one cycle before that edge and again just after it, so that an off-by-one in either direction is caught. Window faults and early services act at the second key's edge. Their interrupt and the reloaded count are sampled at the falling edge right after that write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ACT_RESET   = 2'd0,
    ACT_IRQ     = 2'd1,
    ACT_IRQ_RST = 2'd2,
    ACT_SPARE   = 2'd3
  } wdt_act_e;

  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_TMO    = 1;
  localparam int unsigned ADR_WIN    = 2;
  localparam int unsigned ADR_SVC    = 3;
  localparam int unsigned ADR_STAT   = 4;
  localparam int unsigned ADR_UNLOCK = 5;
  localparam int unsigned ADR_COUNT  = 6;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_WIN  = 1;
  localparam int unsigned CB_ACT  = 2;
  localparam int unsigned CB_HALT = 4;
  localparam int unsigned CB_SOFT = 5;
  localparam int unsigned CB_HARD = 6;

  localparam logic [15:0] SVC_KEY_A = 16'hA602;
  localparam logic [15:0] SVC_KEY_B = 16'hB480;
  localparam logic [15:0] UNL_KEY_A = 16'hC520;
  localparam logic [15:0] UNL_KEY_B = 16'hD928;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
  parameter int          DATA_W = 32,
  parameter logic [15:0] KEY_A  = 16'h0001,
  parameter logic [15:0] KEY_B  = 16'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  localparam logic [DATA_W-1:0] FULL_A = DATA_W'(KEY_A);
  localparam logic [DATA_W-1:0] FULL_B = DATA_W'(KEY_B);

  logic armed_q;

  assign hit = wr && armed_q && (data == FULL_B);

  // Any write re-evaluates the arm: only the first key arms, anything else cancels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= (data == FULL_A);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_RST = 160000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              expired
);
  localparam logic [DATA_W-1:0] INIT = DATA_W'(TIMEOUT_RST);

  logic [DATA_W-1:0] cnt_q;

  assign count   = cnt_q;
  // A service reload in the same cycle takes priority over reaching zero.
  assign expired = run && (cnt_q == '0) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= INIT;
    else if (reload || expired) cnt_q <= reload_val;
    else if (run)               cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int TIMEOUT_RST = 160000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              lp_halt,
  output logic              wdt_irq,
  output logic              wdt_reset_req
);
  localparam logic [DATA_W-1:0] TMO_INIT = DATA_W'(TIMEOUT_RST);
  localparam int unsigned       CTRL_W   = CB_HARD + 1;

  logic              en_q, win_q, halt_en_q, soft_q, hard_q;
  wdt_act_e          act_q;
  logic [DATA_W-1:0] timeout_q, window_q;
  logic              irq_q, primed_q, rstreq_q;

  logic              locked, cfg_wr_ok, run;
  logic              svc_hit, unl_hit, win_fault, svc_good, cnt_expired, expire_evt;
  logic [DATA_W-1:0] count;
  logic [CTRL_W-1:0] ctrl_rd;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  assign locked    = soft_q || hard_q;
  assign cfg_wr_ok = reg_we && !locked;
  assign run       = en_q && !(halt_en_q && lp_halt);

  wdt_keyseq #(.DATA_W(DATA_W), .KEY_A(SVC_KEY_A), .KEY_B(SVC_KEY_B)) u_svc_key (
    .clk(clk), .rst_n(rst_n), .wr(reg_we && at(reg_addr, ADR_SVC)),
    .data(reg_wdata), .hit(svc_hit)
  );

  wdt_keyseq #(.DATA_W(DATA_W), .KEY_A(UNL_KEY_A), .KEY_B(UNL_KEY_B)) u_unl_key (
    .clk(clk), .rst_n(rst_n), .wr(reg_we && at(reg_addr, ADR_UNLOCK)),
    .data(reg_wdata), .hit(unl_hit)
  );

  assign win_fault = svc_hit && win_q && (count > window_q);
  assign svc_good  = svc_hit && !win_fault;

  wdt_counter #(.DATA_W(DATA_W), .TIMEOUT_RST(TIMEOUT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(svc_hit),
    .reload_val(timeout_q), .count(count), .expired(cnt_expired)
  );

  assign expire_evt = cnt_expired || win_fault;

  // Configuration registers and freeze bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b1;
      win_q     <= 1'b0;
      act_q     <= ACT_RESET;
      halt_en_q <= 1'b0;
      soft_q    <= 1'b0;
      hard_q    <= 1'b0;
      timeout_q <= TMO_INIT;
      window_q  <= '0;
    end else begin
      if (cfg_wr_ok && at(reg_addr, ADR_CTRL)) begin
        en_q      <= reg_wdata[CB_EN];
        win_q     <= reg_wdata[CB_WIN];
        act_q     <= wdt_act_e'(reg_wdata[CB_ACT +: 2]);
        halt_en_q <= reg_wdata[CB_HALT];
        soft_q    <= reg_wdata[CB_SOFT];
        hard_q    <= reg_wdata[CB_HARD];
      end
      if (cfg_wr_ok && at(reg_addr, ADR_TMO)) timeout_q <= reg_wdata;
      if (cfg_wr_ok && at(reg_addr, ADR_WIN)) window_q  <= reg_wdata;
      if (unl_hit && !hard_q) soft_q <= 1'b0;
    end
  end

  // Timeout response.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      primed_q <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      if (reg_we && at(reg_addr, ADR_STAT) && reg_wdata[0]) irq_q <= 1'b0;
      if (svc_good) primed_q <= 1'b0;
      if (expire_evt) begin
        unique case (act_q)
          ACT_IRQ: irq_q <= 1'b1;
          ACT_IRQ_RST: begin
            if (primed_q) rstreq_q <= 1'b1;
            else begin
              primed_q <= 1'b1;
              irq_q    <= 1'b1;
            end
          end
          default: rstreq_q <= 1'b1;
        endcase
      end
    end
  end

  assign wdt_irq       = irq_q;
  assign wdt_reset_req = rstreq_q;
  assign ctrl_rd       = {hard_q, soft_q, halt_en_q, act_q, win_q, en_q};

  always_comb begin
    reg_rdata = '0;
    if (at(reg_addr, ADR_CTRL))       reg_rdata = DATA_W'(ctrl_rd);
    else if (at(reg_addr, ADR_TMO))   reg_rdata = timeout_q;
    else if (at(reg_addr, ADR_WIN))   reg_rdata = window_q;
    else if (at(reg_addr, ADR_STAT))  reg_rdata = DATA_W'(irq_q);
    else if (at(reg_addr, ADR_COUNT)) reg_rdata = count;
  end
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              wdt_irq,
  input logic              wdt_reset_req,
  input logic              soft_q,
  input logic              hard_q,
  input logic [DATA_W-1:0] timeout_q,
  input logic [DATA_W-1:0] count,
  input logic              run,
  input logic              svc_hit,
  input logic              svc_good,
  input logic              cnt_expired
);
  // R2
  svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_good |=> (count == $past(timeout_q)));

  // R3
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> wdt_reset_req);

  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(ADR_STAT) && reg_wdata[0] && !cnt_expired) |=> !wdt_irq);

  // R7
  locked_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(ADR_TMO) && (soft_q || hard_q)) |=> $stable(timeout_q));

  // R8
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> hard_q);

  // R10
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc_hit) |=> $stable(count));
endmodule

bind wdt_window wdt_window_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .wdt_irq(wdt_irq), .wdt_reset_req(wdt_reset_req),
  .soft_q(soft_q), .hard_q(hard_q), .timeout_q(timeout_q), .count(count),
  .run(run), .svc_hit(svc_hit), .svc_good(svc_good), .cnt_expired(cnt_expired)
);

// File: tb/wdt_window_tb.sv
module wdt_window_tb;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          lp_halt = 1'b0;
  logic          wdt_irq, wdt_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_window u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lp_halt(lp_halt),
    .wdt_irq(wdt_irq), .wdt_reset_req(wdt_reset_req)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic service();
    wr(3, 32'hA602);
    wr(3, 32'hB480);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lp_halt = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] v, a, b;
    do_reset();
    rd(0, v); chk("R1 ctrl", v, 1);
    rd(1, v); chk("R1 timeout", v, 160000);
    rd(2, v); chk("R1 window", v, 0);
    chk("R1 irq", DW'(wdt_irq), 0);
    chk("R1 rst", DW'(wdt_reset_req), 0);
    rd(6, a); cyc(3); rd(6, b);
    chk("R1 count falls", b, a - 3);
  endtask

  task automatic t_keys();
    logic [DW-1:0] v;
    do_reset();
    wr(1, 20);
    service();
    rd(6, v); chk("R2 reload", v, 20);
    cyc(5);
    wr(3, 32'hB480); wr(3, 32'hA602); wr(3, 32'h1234); wr(3, 32'hB480);
    rd(6, v); chk("R2 bad sequence ignored", v, 11);
    service();
    rd(6, v); chk("R2 reload again", v, 20);
  endtask

  task automatic t_reset_resp();
    do_reset();
    wr(1, 20);
    service();
    cyc(20);
    chk("R3 not yet", DW'(wdt_reset_req), 0);
    cyc(1);
    chk("R3 expiry", DW'(wdt_reset_req), 1);
    cyc(30);
    chk("R3 held", DW'(wdt_reset_req), 1);
  endtask

  task automatic t_irq_resp();
    logic [DW-1:0] v;
    do_reset();
    wr(1, 10);
    wr(0, 5);
    service();
    cyc(10);
    chk("R4 not yet", DW'(wdt_irq), 0);
    cyc(1);
    chk("R4 irq", DW'(wdt_irq), 1);
    chk("R4 no rst", DW'(wdt_reset_req), 0);
    wr(4, 0);
    rd(4, v); chk("R4 zero write keeps flag", v, 1);
    wr(4, 1);
    chk("R4 cleared", DW'(wdt_irq), 0);
    cyc(25);
    chk("R4 again", DW'(wdt_irq), 1);
    chk("R4 still no rst", DW'(wdt_reset_req), 0);
  endtask

  task automatic t_irq_rst_resp();
    do_reset();
    wr(1, 10);
    wr(0, 9);
    service();
    cyc(11);
    chk("R5 first irq", DW'(wdt_irq), 1);
    chk("R5 first no rst", DW'(wdt_reset_req), 0);
    service();
    chk("R5 service keeps irq", DW'(wdt_irq), 1);
    cyc(11);
    chk("R5 serviced no rst", DW'(wdt_reset_req), 0);
    cyc(10);
    chk("R5 second not yet", DW'(wdt_reset_req), 0);
    cyc(1);
    chk("R5 second expiry rst", DW'(wdt_reset_req), 1);
  endtask

  task automatic t_window();
    logic [DW-1:0] v;
    do_reset();
    wr(1, 20);
    wr(2, 5);
    wr(0, 7);
    service();
    chk("R6 early fault irq", DW'(wdt_irq), 1);
    rd(6, v); chk("R6 fault reload", v, 20);
    wr(4, 1);
    cyc(15);
    service();
    chk("R6 open window no irq", DW'(wdt_irq), 0);
    rd(6, v); chk("R6 open window reload", v, 20);
  endtask

  task automatic t_locks();
    logic [DW-1:0] v;
    do_reset();
    wr(1, 20);
    wr(0, 33);
    wr(1, 55);
    rd(1, v); chk("R7 soft blocks timeout", v, 20);
    wr(5, 32'hD928); wr(5, 32'hC520); wr(5, 32'h1111); wr(5, 32'hD928);
    wr(1, 66);
    rd(1, v); chk("R7 bad unlock", v, 20);
    wr(5, 32'hC520); wr(5, 32'hD928);
    rd(0, v); chk("R7 unlocked ctrl", v, 1);
    wr(1, 55);
    rd(1, v); chk("R7 write after unlock", v, 55);
    wr(0, 65);
    wr(1, 77);
    rd(1, v); chk("R8 hard blocks timeout", v, 55);
    wr(5, 32'hC520); wr(5, 32'hD928);
    wr(0, 0);
    rd(0, v); chk("R8 unlock ignored", v, 65);
    do_reset();
    rd(0, v); chk("R8 reset clears", v, 1);
  endtask

  task automatic t_halt();
    logic [DW-1:0] a, b, c;
    do_reset();
    wr(0, 17);
    lp_halt = 1'b1;
    rd(6, a); cyc(5); rd(6, b);
    chk("R9 paused", b, a);
    lp_halt = 1'b0;
    cyc(5); rd(6, c);
    chk("R9 resumes", c, b - 5);
    lp_halt = 1'b1;
    wr(0, 1);
    rd(6, a); cyc(5); rd(6, b);
    chk("R9 input ignored", b, a - 5);
    lp_halt = 1'b0;
  endtask

  task automatic t_disable();
    logic [DW-1:0] a, b;
    do_reset();
    wr(1, 3);
    service();
    wr(0, 0);
    rd(6, a); cyc(12); rd(6, b);
    chk("R10 count held", b, a);
    chk("R10 no rst", DW'(wdt_reset_req), 0);
    chk("R10 no irq", DW'(wdt_irq), 0);
  endtask

  initial begin
    cyc(1);
    t_reset_state();
    t_keys();
    t_reset_resp();
    t_irq_resp();
    t_irq_rst_resp();
    t_window();
    t_locks();
    t_halt();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule